// File: doc/BRIEF.md
# Cascadable Registered Bus Comparator Slice

This block is one slice of a wide comparator. It holds a byte in a register that can keep its value, shift serially, load from a shared bidirectional bus, or drive its contents back onto that bus. A comparator continuously checks the stored byte against the value currently on the bus. It reports the result on three status lines that behave like open-collector outputs: 1 means released and 0 means pulled low. A compare-mode input selects an unsigned or a two's complement comparison.

A priority input and a priority output let slices be chained. The more significant slice decides the result when its bytes differ. When its bytes are equal, it hands the decision down to the next slice. The status lines of all slices are combined as a wired-AND. In the chain, the priority pins also serve as the serial data path of the register.

Top module: `rcmp_slice`

## Requirements
- R1: `op_sel` is {S0,S1}. The value 2'b00 keeps the register unchanged across clock edges. The value 2'b11 loads the value on `data_io` into the register on the rising clock edge.
- R2: With `op_sel` = 2'b01, the slice drives the register onto `data_io` and the register is not changed by clock edges. In every other mode `data_io` is high-impedance.
- R3: With `op_sel` = 2'b10, each rising edge shifts the register toward the MSB and fills bit 0 from `pri_si`. In that mode `pri_so` shows the register's MSB.
- R4: When `rst` is high at a rising edge, the register becomes zero. The reset is synchronous.
- R5: With `cmp_signed` = 0, the register and the bus are compared as unsigned numbers.
- R6: With `cmp_signed` = 1, both are compared as two's complement numbers.
- R7: With `stat_dis` = 0 and `pri_si` = 1, exactly one status line is 1: the one for the true relation of register to bus (`st_gt`, `st_eq` or `st_lt`). The other two are 0.
- R8: With `stat_dis` = 1, `st_gt`, `st_eq` and `st_lt` are all 1, whatever the data.
- R9: With `stat_dis` = 0 and `pri_si` = 0, `st_gt` and `st_lt` are 1, and `st_eq` is 1 exactly when the register equals the bus.
- R10: In every mode other than shift, `pri_so` is 1 exactly when `pri_si` is 1 and the register equals the bus.
- R11: Three slices chained as described (see Verification) give the correct greater/equal/less result of a 24-bit compare on the wired-AND of their status lines, both signed and unsigned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset of the register |
| op_sel | input | 2 | Operation {S0,S1}: 00 hold, 01 read, 10 shift, 11 load |
| cmp_signed | input | 1 | 0 unsigned compare, 1 two's complement compare |
| stat_dis | input | 1 | 1 releases all status lines |
| pri_si | input | 1 | Priority input and serial data input |
| pri_so | output | 1 | Priority output and serial data output |
| data_io | inout | WIDTH | Bidirectional data bus |
| st_gt | output | 1 | Register greater than bus (1 = released) |
| st_eq | output | 1 | Register equal to bus (1 = released) |
| st_lt | output | 1 | Register less than bus (1 = released) |

## Verification
The bench builds every slice with the default WIDTH of 8. At that width, the sign-boundary bytes 0x7F, 0x80, 0x00 and 0xFF can be hit directly. Shift sequences that push bits through the MSB into `pri_so` are also short. Three such slices are chained into a 24-bit comparator. The most significant slice has `pri_si` tied high and its `stat_dis` fed from its own `pri_so`. The middle slice takes the top slice's `pri_so` on `pri_si` and its own `pri_so` on `stat_dis`. The least significant slice takes the middle slice's `pri_so` on `pri_si` and has `stat_dis` tied low. Only the top slice gets `cmp_signed`. This chain makes it possible to check equality rippling across bytes and signed decisions made in the upper byte.

// File: rtl/rcmp_pkg.sv
package rcmp_pkg;

    // Operation select, packed as {S0,S1}
    typedef enum logic [1:0] {
        OP_HOLD  = 2'b00,
        OP_READ  = 2'b01,
        OP_SHIFT = 2'b10,
        OP_LOAD  = 2'b11
    } op_e;

    typedef enum logic [1:0] {
        REL_LT = 2'd0,
        REL_EQ = 2'd1,
        REL_GT = 2'd2
    } rel_e;

    // Status lines, 1 = released
    typedef struct packed {
        logic gt;
        logic eq;
        logic lt;
    } stat_t;

    localparam stat_t STAT_RELEASED = '{gt: 1'b1, eq: 1'b1, lt: 1'b1};

    function automatic stat_t stat_of_rel(rel_e r);
        stat_t s;
        s.gt = (r == REL_GT);
        s.eq = (r == REL_EQ);
        s.lt = (r == REL_LT);
        return s;
    endfunction

endpackage

// File: rtl/rcmp_store.sv
module rcmp_store
    import rcmp_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  op_e              op,
    input  logic [WIDTH-1:0] bus_in,
    input  logic             ser_in,
    output logic [WIDTH-1:0] q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else begin
            unique case (op)
                OP_LOAD:  q <= bus_in;
                OP_SHIFT: q <= {q[WIDTH-2:0], ser_in};
                default:  q <= q;
            endcase
        end
    end

    assert_reset_clears_R4: assert property (@(posedge clk)
        rst |=> (q == '0));

    assert_hold_keeps_R1: assert property (@(posedge clk) disable iff (rst)
        (op == OP_HOLD) |=> $stable(q));

    assert_load_takes_bus_R1: assert property (@(posedge clk) disable iff (rst)
        (op == OP_LOAD) |=> (q == $past(bus_in)));

    assert_read_keeps_R2: assert property (@(posedge clk) disable iff (rst)
        (op == OP_READ) |=> $stable(q));

    assert_shift_moves_R3: assert property (@(posedge clk) disable iff (rst)
        (op == OP_SHIFT) |=> (q == {$past(q[WIDTH-2:0]), $past(ser_in)}));

endmodule

// File: rtl/rcmp_compare.sv
module rcmp_compare
    import rcmp_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] reg_val,
    input  logic [WIDTH-1:0] bus_val,
    input  logic             use_sign,
    output rel_e             rel
);

    localparam int EXT = WIDTH + 1;

    logic signed [EXT-1:0] ext_reg;
    logic signed [EXT-1:0] ext_bus;

    // Sign-extend only in signed mode; otherwise zero-extend
    always_comb begin
        ext_reg = $signed({use_sign & reg_val[WIDTH-1], reg_val});
        ext_bus = $signed({use_sign & bus_val[WIDTH-1], bus_val});
        if (ext_reg == ext_bus)     rel = REL_EQ;
        else if (ext_reg > ext_bus) rel = REL_GT;
        else                        rel = REL_LT;
    end

    assert_eq_matches_R5: assert property (@(posedge clk) disable iff (rst)
        (rel == REL_EQ) |-> (reg_val == bus_val));

    assert_unsigned_order_R5: assert property (@(posedge clk) disable iff (rst)
        (!use_sign && rel == REL_GT) |-> (reg_val > bus_val));

    assert_sign_decides_R6: assert property (@(posedge clk) disable iff (rst)
        (use_sign && reg_val[WIDTH-1] && !bus_val[WIDTH-1]) |-> (rel == REL_LT));

endmodule

// File: rtl/rcmp_status.sv
module rcmp_status
    import rcmp_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  rel_e  rel,
    input  logic  dis,
    input  logic  pri_in,
    output stat_t st
);

    always_comb begin
        if (dis) begin
            st = STAT_RELEASED;
        end else if (!pri_in) begin
            st    = STAT_RELEASED;
            st.eq = (rel == REL_EQ);
        end else begin
            st = stat_of_rel(rel);
        end
    end

    assert_one_released_R7: assert property (@(posedge clk) disable iff (rst)
        (!dis && pri_in) |-> ($countones(st) == 1));

    assert_disabled_released_R8: assert property (@(posedge clk) disable iff (rst)
        dis |-> (st.gt && st.eq && st.lt));

    assert_low_priority_R9: assert property (@(posedge clk) disable iff (rst)
        (!dis && !pri_in) |-> (st.gt && st.lt));

endmodule

// File: rtl/rcmp_slice.sv
module rcmp_slice
    import rcmp_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       op_sel,
    input  logic             cmp_signed,
    input  logic             stat_dis,
    input  logic             pri_si,
    output logic             pri_so,
    inout  wire  [WIDTH-1:0] data_io,
    output logic             st_gt,
    output logic             st_eq,
    output logic             st_lt
);

    op_e              op;
    logic [WIDTH-1:0] q;
    logic             bus_oe;
    rel_e             rel;
    stat_t            st;

    assign op     = op_e'(op_sel);
    assign bus_oe = (op == OP_READ);
    assign data_io = bus_oe ? q : {WIDTH{1'bz}};

    rcmp_store #(.WIDTH(WIDTH)) u_store (
        .clk    (clk),
        .rst    (rst),
        .op     (op),
        .bus_in (data_io),
        .ser_in (pri_si),
        .q      (q)
    );

    rcmp_compare #(.WIDTH(WIDTH)) u_cmp (
        .clk      (clk),
        .rst      (rst),
        .reg_val  (q),
        .bus_val  (data_io),
        .use_sign (cmp_signed),
        .rel      (rel)
    );

    rcmp_status u_stat (
        .clk    (clk),
        .rst    (rst),
        .rel    (rel),
        .dis    (stat_dis),
        .pri_in (pri_si),
        .st     (st)
    );

    // Priority / serial output
    always_comb begin
        if (op == OP_SHIFT) pri_so = q[WIDTH-1];
        else                pri_so = pri_si && (rel == REL_EQ);
    end

    assign st_gt = st.gt;
    assign st_eq = st.eq;
    assign st_lt = st.lt;

    assert_drive_only_read_R2: assert property (@(posedge clk) disable iff (rst)
        bus_oe |-> (op_sel == 2'b01));

    assert_pri_needs_equal_R10: assert property (@(posedge clk) disable iff (rst)
        (op != OP_SHIFT && pri_so && !stat_dis) |-> (st_eq && !st_gt && !st_lt));

    assert_pri_blocked_R10: assert property (@(posedge clk) disable iff (rst)
        (op != OP_SHIFT && !pri_si) |-> !pri_so);

endmodule

// File: tb/test_rcmp_slice.sv
module test_rcmp_slice;

    localparam int W = 8;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic       rst = 1'b1;
    logic [1:0] op  = 2'b00;
    logic       sgn = 1'b0, dis = 1'b0, pin = 1'b1;
    logic       oe  = 1'b1;
    logic [W-1:0] val = '0;
    wire  [W-1:0] bus_u;
    logic so_u, gt_u, eq_u, lt_u;
    assign bus_u = oe ? val : {W{1'bz}};

    rcmp_slice #(.WIDTH(W)) i_rcmp_slice (
        .clk(clk), .rst(rst), .op_sel(op), .cmp_signed(sgn), .stat_dis(dis),
        .pri_si(pin), .pri_so(so_u), .data_io(bus_u),
        .st_gt(gt_u), .st_eq(eq_u), .st_lt(lt_u));

    // Three-slice chain: index 2 is most significant
    logic [23:0] c_val = '0;
    logic        c_sgn = 1'b0;
    wire  [W-1:0] cb0, cb1, cb2;
    logic so0, so1, so2;
    logic g0, e0, l0, g1, e1, l1, g2, e2, l2;
    assign cb0 = c_val[7:0];
    assign cb1 = c_val[15:8];
    assign cb2 = c_val[23:16];

    rcmp_slice #(.WIDTH(W)) i_rcmp_slice_c2 (
        .clk(clk), .rst(rst), .op_sel(op), .cmp_signed(c_sgn), .stat_dis(so2),
        .pri_si(1'b1), .pri_so(so2), .data_io(cb2), .st_gt(g2), .st_eq(e2), .st_lt(l2));
    rcmp_slice #(.WIDTH(W)) i_rcmp_slice_c1 (
        .clk(clk), .rst(rst), .op_sel(op), .cmp_signed(1'b0), .stat_dis(so1),
        .pri_si(so2), .pri_so(so1), .data_io(cb1), .st_gt(g1), .st_eq(e1), .st_lt(l1));
    rcmp_slice #(.WIDTH(W)) i_rcmp_slice_c0 (
        .clk(clk), .rst(rst), .op_sel(op), .cmp_signed(1'b0), .stat_dis(1'b0),
        .pri_si(so1), .pri_so(so0), .data_io(cb0), .st_gt(g0), .st_eq(e0), .st_lt(l0));

    // Scoreboard
    typedef enum int { K_STAT, K_BUS, K_CHAIN } kind_e;
    typedef struct {
        kind_e       kind;
        logic [31:0] exp;
        string       req;
    } item_t;
    item_t sb_q[$];
    int n_chk = 0, n_fail = 0;
    bit done = 0;

    always @(negedge clk) begin
        while (sb_q.size() > 0) begin
            item_t it;
            logic [31:0] act;
            it = sb_q.pop_front();
            case (it.kind)
                K_STAT:  act = {28'd0, gt_u, eq_u, lt_u, so_u};
                K_BUS:   act = {24'd0, bus_u};
                default: act = {29'd0, g0 & g1 & g2, e0 & e1 & e2, l0 & l1 & l2};
            endcase
            n_chk++;
            if (act !== it.exp) begin
                n_fail++;
                $display("FAIL %s: actual %h expected %h", it.req, act, it.exp);
            end
        end
    end

    task automatic push(kind_e k, logic [31:0] e, string r);
        item_t it;
        it.kind = k; it.exp = e; it.req = r;
        sb_q.push_back(it);
    endtask

    task automatic tick();
        @(posedge clk); #1;
    endtask

    // Reference status of one slice: {gt,eq,lt}
    function automatic logic [2:0] ref_stat(logic d, logic p, logic [7:0] a, logic [7:0] b, logic s);
        logic e, g;
        e = (a == b);
        g = s ? ($signed(a) > $signed(b)) : (a > b);
        if (d)  return 3'b111;
        if (!p) return {1'b1, e, 1'b1};
        return {g, e, !g && !e};
    endfunction

    logic [7:0] model = '0;

    task automatic load_u(logic [7:0] v);
        op = 2'b11; oe = 1; val = v; tick(); model = v;
    endtask

    task automatic cmp_u(logic [7:0] b, logic s, logic d, logic p, string r);
        op = 2'b00; oe = 1; val = b; sgn = s; dis = d; pin = p;
        push(K_STAT, {28'd0, ref_stat(d, p, model, b, s), p && (model == b)}, r);
        tick();
    endtask

    task automatic read_u(string r);
        op = 2'b01; oe = 0;
        push(K_BUS, {24'd0, model}, r);
        tick();
    endtask

    task automatic chain_case(logic [23:0] a, logic [23:0] b, logic s);
        logic g, e;
        op = 2'b11; c_val = a; tick();
        op = 2'b00; c_val = b; c_sgn = s;
        e = (a == b);
        g = s ? ($signed(a) > $signed(b)) : (a > b);
        push(K_CHAIN, {29'd0, g, e, !g && !e}, s ? "R11 signed R6" : "R11 unsigned");
        tick();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        tick(); tick();
        rst = 0;
        // R4: reset state
        cmp_u(8'h00, 0, 0, 1, "R4 reset zero");
        read_u("R4 reset read");
        // R1 load, R2 read stability
        load_u(8'h5A);
        read_u("R1 load");
        read_u("R2 read keeps");
        read_u("R2 read keeps again");
        op = 2'b00; oe = 1; val = 8'hC3; tick(); tick();
        read_u("R1 hold keeps");
        // R5 / R6 boundary pairs
        load_u(8'h80); cmp_u(8'h7F, 0, 0, 1, "R5 R7 80>7F unsigned");
        cmp_u(8'h7F, 1, 0, 1, "R6 R7 80<7F signed");
        load_u(8'h7F); cmp_u(8'h80, 1, 0, 1, "R6 7F>80 signed");
        load_u(8'hFF); cmp_u(8'h00, 0, 0, 1, "R5 FF>00");
        cmp_u(8'h00, 1, 0, 1, "R6 FF<00 signed");
        cmp_u(8'hFF, 1, 0, 1, "R7 R10 equal");
        // R8, R9, R10
        cmp_u(8'hFF, 0, 1, 1, "R8 disabled equal");
        cmp_u(8'h10, 0, 1, 1, "R8 disabled greater");
        cmp_u(8'hFF, 0, 0, 0, "R9 R10 low priority equal");
        cmp_u(8'h10, 0, 0, 0, "R9 low priority unequal");
        for (int i = 0; i < 40; i++) begin
            logic [7:0] a, b;
            a = 8'($urandom); b = (i % 5 == 0) ? a : 8'($urandom);
            load_u(a);
            cmp_u(b, 1'($urandom), 1'($urandom), 1'($urandom), "R5 R6 R7 R9 random");
        end
        // R3 shift
        load_u(8'h81);
        for (int i = 0; i < 6; i++) begin
            logic bit_in;
            bit_in = (i % 3) != 1;
            op = 2'b10; oe = 1; val = 8'h00; sgn = 0; dis = 0; pin = bit_in;
            push(K_STAT, {28'd0, ref_stat(0, bit_in, model, 8'h00, 0), model[7]}, "R3 shift out");
            tick();
            model = {model[6:0], bit_in};
        end
        read_u("R3 shifted value");
        // R4 reset mid-run
        load_u(8'hEE); rst = 1; op = 2'b00; tick(); rst = 0; model = 8'h00;
        read_u("R4 sync reset");
        // R11 chain
        chain_case(24'h123456, 24'h123456, 0);
        chain_case(24'h123457, 24'h123456, 0);
        chain_case(24'h123456, 24'h124456, 0);
        chain_case(24'h800000, 24'h7FFFFF, 0);
        chain_case(24'h800000, 24'h7FFFFF, 1);
        chain_case(24'hFFFFFF, 24'h000000, 1);
        chain_case(24'h00FF00, 24'h00FE01, 1);
        for (int i = 0; i < 40; i++) begin
            logic [23:0] a, b;
            a = 24'($urandom);
            b = (i % 4 == 0) ? {a[23:8], 8'($urandom)} : 24'($urandom);
            chain_case(a, b, 1'($urandom));
        end
        tick();
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule